// File: doc/BRIEF.md
# Memory-Type-Aware Direct-Mapped Cache

This block is a small direct-mapped data cache. It sits between a processor request port and a memory bus port. Each processor request carries two memory-type codes: the page-level type and the range-level type. The block resolves them into one effective type. That type selects how the access is served: bypassing the cache, write-through, write-protect or write-back. The cache holds tags, line data, a valid bit and a dirty bit for each line. A line that was written under write-back is copied to memory when it is evicted, or when an uncached or write-protect access needs it out of the way.

The processor port handles one transaction at a time. A request is taken in the cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` then stays low until the one-cycle `cpu_rsp_valid` pulse has been given.

The memory port is a valid/ready request channel with a line-wide data path and a per-word mask. Back-pressure rule: while `mem_req_valid` is high and `mem_req_ready` is low, every request field holds its value. A request is consumed in the cycle where both are high. Write requests complete at that handshake. A read request is answered later by a single `mem_rsp_valid` beat carrying the full line, and the block is always able to take that beat.

Every memory request carries the resolved memory type, so the memory side can order or combine bypass traffic.

Top module: `mtc_cache`

## Requirements
- R1: The legal type codes are 0 (uncacheable), 1 (write-combining), 4 (write-through), 5 (write-protect), 6 (write-back) and 7 (uncacheable-minus). A page type of 7 resolves to 1 when the range type is 1, and resolves to 0 otherwise. Every other code resolves to itself. `mem_req_mtype` always carries the resolved code.
- R2: Any other page code (2, 3, 8 to 255, including 255) is answered with `cpu_rsp_error`=1 two cycles after acceptance. Such a request issues no memory request and leaves the cache contents unchanged.
- R3: Resolved types 0 and 1 are bypass types. Each bypass access issues exactly one single-word memory request, with one mask bit set, in the resolved type, and never allocates a line. If the addressed line is present, it is first written back (when dirty) and then invalidated. A bypass read returns the memory word.
- R4: Under types 4, 5 and 6, a read that hits returns the cached word two cycles after acceptance, with no memory traffic. A read that misses fetches the line (full mask), installs it clean, and returns the word.
- R5: A write-through write always issues one single-word memory write. On a hit it also updates the cached word. On a miss it allocates nothing.
- R6: A write-protect write issues one single-word memory write. A matching line is invalidated (after write-back if dirty) instead of being updated.
- R7: A write-back write that misses first fetches the line and then writes the word into it. Write-back writes mark the line dirty and produce no memory write until that line leaves the cache. A write-back write hit responds two cycles after acceptance.
- R8: When a line fetch must replace a valid dirty line, the victim is written to memory as one full-mask line write, and this happens before the fetch request is issued.
- R9: After reset `cpu_req_ready`=1 and no response or memory request is pending. After a request is accepted, `cpu_req_ready` is low until the response, and `cpu_rsp_valid` is a single-cycle pulse during which `cpu_req_ready` is low.
- R10: While `mem_req_valid`=1 and `mem_req_ready`=0, the address, write flag, mask, write data and type of the memory request stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block idle and able to accept |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Write word |
| cpu_req_mtype | input | 8 | Page-level memory type code |
| cpu_req_range_mtype | input | 8 | Range-level memory type code |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DW | Read word (0 for writes) |
| cpu_rsp_error | output | 1 | Request had an illegal type |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word address (line aligned for line transfers) |
| mem_req_mask | output | WPL | Words of the line involved |
| mem_req_wdata | output | DW*WPL | Line-wide write data |
| mem_req_mtype | output | 8 | Resolved memory type of the access |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | DW*WPL | Read line |

## Verification
Two functions can complete in the same cycle. When an uncached access or a write-protect write finds its own line dirty, the final handshake of the victim write-back and the invalidation of that line both happen in that cycle, and the word access starts in the next one. The bench provokes this with long mixed sequences over a small address window. Write-back writes and bypass or write-protect accesses often hit the same line, and the memory model inserts ready stalls and variable response delays. A reference model of valid, tag and dirty bits predicts, for each access, the number of line writes, line reads, word writes and word reads, and the order of write-back against fetch. Every read is compared to the last value written, and after a final uncached sweep the memory image is compared to it as well.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam logic [7:0] MT_UC  = 8'd0;
  localparam logic [7:0] MT_WC  = 8'd1;
  localparam logic [7:0] MT_WT  = 8'd4;
  localparam logic [7:0] MT_WP  = 8'd5;
  localparam logic [7:0] MT_WB  = 8'd6;
  localparam logic [7:0] MT_UCM = 8'd7;

  typedef enum logic [1:0] {POL_BYPASS, POL_WT, POL_WP, POL_WB} policy_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_FLUSH, S_FILL, S_FILLW, S_BUS, S_BUSW, S_RESP
  } state_t;
endpackage

// File: rtl/mtc_type_resolve.sv
module mtc_type_resolve
  import mtc_pkg::*;
(
  input  logic [7:0] page_type,
  input  logic [7:0] range_type,
  output logic [7:0] eff_type,
  output policy_t    policy,
  output logic       illegal
);
  always_comb begin
    eff_type = page_type;
    policy   = POL_BYPASS;
    illegal  = 1'b0;
    case (page_type)
      MT_UC, MT_WC: policy = POL_BYPASS;
      MT_WT:        policy = POL_WT;
      MT_WP:        policy = POL_WP;
      MT_WB:        policy = POL_WB;
      MT_UCM:       eff_type = (range_type == MT_WC) ? MT_WC : MT_UC;
      default:      illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/mtc_store.sv
module mtc_store #(
  parameter int LINES = 4,
  parameter int IDXW  = 2,
  parameter int TAGW  = 5,
  parameter int DW    = 8,
  parameter int WPL   = 2,
  parameter int OFFW  = 1,
  parameter int LW    = DW * WPL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx,
  output logic            rd_valid,
  output logic            rd_dirty,
  output logic [TAGW-1:0] rd_tag,
  output logic [LW-1:0]   rd_line,
  input  logic            fill_en,
  input  logic [TAGW-1:0] fill_tag,
  input  logic [LW-1:0]   fill_line,
  input  logic            word_en,
  input  logic [OFFW-1:0] word_off,
  input  logic [DW-1:0]   word_data,
  input  logic            word_dirty,
  input  logic            inval_en,
  input  logic            clean_en
);
  logic            val_q [LINES];
  logic            dty_q [LINES];
  logic [TAGW-1:0] tag_q [LINES];
  logic [LW-1:0]   dat_q [LINES];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LINES; l++) begin
      if (!rst_n) begin
        val_q[l] <= 1'b0;
        dty_q[l] <= 1'b0;
        tag_q[l] <= '0;
        dat_q[l] <= '0;
      end else if (idx == IDXW'(l)) begin
        if (fill_en) begin
          val_q[l] <= 1'b1;
          dty_q[l] <= 1'b0;
          tag_q[l] <= fill_tag;
          dat_q[l] <= fill_line;
        end
        if (word_en) begin
          for (int w = 0; w < WPL; w++)
            if (word_off == OFFW'(w)) dat_q[l][w*DW +: DW] <= word_data;
          dty_q[l] <= dty_q[l] | word_dirty;
        end
        if (clean_en) dty_q[l] <= 1'b0;
        if (inval_en) begin
          val_q[l] <= 1'b0;
          dty_q[l] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid = val_q[idx];
  assign rd_dirty = dty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_line  = dat_q[idx];
endmodule

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int WPL  = 2,
  parameter int IDXW = 2,
  parameter int OFFW = 1,
  parameter int TAGW = 5,
  parameter int LW   = DW * WPL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req_valid,
  output logic            cpu_req_ready,
  input  logic            cpu_req_write,
  input  logic [AW-1:0]   cpu_req_addr,
  input  logic [DW-1:0]   cpu_req_wdata,
  input  logic [7:0]      cpu_req_mtype,
  input  logic [7:0]      cpu_req_range_mtype,
  output logic            cpu_rsp_valid,
  output logic [DW-1:0]   cpu_rsp_rdata,
  output logic            cpu_rsp_error,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [WPL-1:0]  mem_req_mask,
  output logic [LW-1:0]   mem_req_wdata,
  output logic [7:0]      mem_req_mtype,
  input  logic            mem_rsp_valid,
  input  logic [LW-1:0]   mem_rsp_data,
  output logic [7:0]      q_page,
  output logic [7:0]      q_range,
  input  logic [7:0]      eff_type,
  input  policy_t         policy,
  input  logic            illegal,
  output logic [IDXW-1:0] st_idx,
  input  logic            rd_valid,
  input  logic            rd_dirty,
  input  logic [TAGW-1:0] rd_tag,
  input  logic [LW-1:0]   rd_line,
  output logic            fill_en,
  output logic [TAGW-1:0] fill_tag,
  output logic            word_en,
  output logic [OFFW-1:0] word_off,
  output logic [DW-1:0]   word_data,
  output logic            word_dirty,
  output logic            inval_en,
  output logic            clean_en
);
  state_t          state, nxt;
  logic            q_write, q_err;
  logic [AW-1:0]   q_addr;
  logic [DW-1:0]   q_wdata, q_rdata;
  logic [TAGW-1:0] q_tag;
  logic            hit, take_hit, take_bus, set_err;
  logic [DW-1:0]   hit_word, bus_word;

  assign q_tag    = q_addr[AW-1 -: TAGW];
  assign st_idx   = q_addr[OFFW +: IDXW];
  assign word_off = q_addr[OFFW-1:0];
  assign hit      = rd_valid && (rd_tag == q_tag);

  always_comb begin
    hit_word = '0;
    bus_word = '0;
    for (int w = 0; w < WPL; w++)
      if (word_off == OFFW'(w)) begin
        hit_word = rd_line[w*DW +: DW];
        bus_word = mem_rsp_data[w*DW +: DW];
      end
  end

  always_comb begin
    nxt = state;
    mem_req_valid = 1'b0;
    fill_en = 1'b0; word_en = 1'b0; word_dirty = 1'b0;
    inval_en = 1'b0; clean_en = 1'b0;
    take_hit = 1'b0; take_bus = 1'b0; set_err = 1'b0;
    case (state)
      S_IDLE: if (cpu_req_valid) nxt = S_DECIDE;
      S_DECIDE: begin
        if (illegal) begin
          set_err = 1'b1;
          nxt = S_RESP;
        end else if (policy == POL_BYPASS || (policy == POL_WP && q_write)) begin
          if (hit && rd_dirty) nxt = S_FLUSH;
          else begin
            inval_en = hit;
            nxt = S_BUS;
          end
        end else if (policy == POL_WT && q_write) begin
          word_en = hit;
          nxt = S_BUS;
        end else if (hit) begin
          word_en    = q_write;
          word_dirty = q_write;
          take_hit   = !q_write;
          nxt = S_RESP;
        end else begin
          nxt = (rd_valid && rd_dirty) ? S_FLUSH : S_FILL;
        end
      end
      S_FLUSH: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          clean_en = 1'b1;
          inval_en = hit;
          nxt = hit ? S_BUS : S_FILL;
        end
      end
      S_FILL: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) nxt = S_FILLW;
      end
      S_FILLW: if (mem_rsp_valid) begin
        fill_en = 1'b1;
        nxt = S_DECIDE;
      end
      S_BUS: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) nxt = q_write ? S_RESP : S_BUSW;
      end
      S_BUSW: if (mem_rsp_valid) begin
        take_bus = 1'b1;
        nxt = S_RESP;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q_write <= 1'b0; q_err <= 1'b0;
      q_addr <= '0; q_wdata <= '0; q_rdata <= '0;
      q_page <= '0; q_range <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && cpu_req_valid) begin
        q_write <= cpu_req_write;
        q_addr  <= cpu_req_addr;
        q_wdata <= cpu_req_wdata;
        q_page  <= cpu_req_mtype;
        q_range <= cpu_req_range_mtype;
        q_err   <= 1'b0;
        q_rdata <= '0;
      end
      if (set_err)  q_err   <= 1'b1;
      if (take_hit) q_rdata <= hit_word;
      if (take_bus) q_rdata <= bus_word;
    end
  end

  assign cpu_req_ready = (state == S_IDLE);
  assign cpu_rsp_valid = (state == S_RESP);
  assign cpu_rsp_rdata = q_rdata;
  assign cpu_rsp_error = q_err;

  assign mem_req_write = (state == S_FLUSH) || (state == S_BUS && q_write);
  assign mem_req_mtype = eff_type;
  assign mem_req_wdata = (state == S_FLUSH) ? rd_line : {WPL{q_wdata}};
  assign fill_tag      = q_tag;
  assign word_data     = q_wdata;

  always_comb begin
    mem_req_addr = q_addr;
    mem_req_mask = '1;
    if (state == S_FLUSH) mem_req_addr = {rd_tag, st_idx, {OFFW{1'b0}}};
    else if (state == S_FILL) mem_req_addr = {q_tag, st_idx, {OFFW{1'b0}}};
    else
      for (int w = 0; w < WPL; w++) mem_req_mask[w] = (word_off == OFFW'(w));
  end
endmodule

// File: rtl/mtc_cache.sv
module mtc_cache
  import mtc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int WPL   = 2,
  parameter int LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_write,
  input  logic [AW-1:0]       cpu_req_addr,
  input  logic [DW-1:0]       cpu_req_wdata,
  input  logic [7:0]          cpu_req_mtype,
  input  logic [7:0]          cpu_req_range_mtype,
  output logic                cpu_rsp_valid,
  output logic [DW-1:0]       cpu_rsp_rdata,
  output logic                cpu_rsp_error,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [AW-1:0]       mem_req_addr,
  output logic [WPL-1:0]      mem_req_mask,
  output logic [DW*WPL-1:0]   mem_req_wdata,
  output logic [7:0]          mem_req_mtype,
  input  logic                mem_rsp_valid,
  input  logic [DW*WPL-1:0]   mem_rsp_data
);
  localparam int OFFW = $clog2(WPL);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW - OFFW;
  localparam int LW   = DW * WPL;

  logic [7:0]      q_page, q_range, eff_type;
  policy_t         policy;
  logic            illegal;
  logic [IDXW-1:0] st_idx;
  logic            rd_valid, rd_dirty;
  logic [TAGW-1:0] rd_tag, fill_tag;
  logic [LW-1:0]   rd_line;
  logic            fill_en, word_en, word_dirty, inval_en, clean_en;
  logic [OFFW-1:0] word_off;
  logic [DW-1:0]   word_data;

  mtc_type_resolve u_resolve (
    .page_type(q_page), .range_type(q_range),
    .eff_type(eff_type), .policy(policy), .illegal(illegal)
  );

  mtc_store #(.LINES(LINES), .IDXW(IDXW), .TAGW(TAGW), .DW(DW),
              .WPL(WPL), .OFFW(OFFW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(st_idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_line(mem_rsp_data),
    .word_en(word_en), .word_off(word_off), .word_data(word_data),
    .word_dirty(word_dirty), .inval_en(inval_en), .clean_en(clean_en)
  );

  mtc_ctrl #(.AW(AW), .DW(DW), .WPL(WPL), .IDXW(IDXW), .OFFW(OFFW),
             .TAGW(TAGW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_mtype(cpu_req_mtype),
    .cpu_req_range_mtype(cpu_req_range_mtype),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_error(cpu_rsp_error),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_mask(mem_req_mask), .mem_req_wdata(mem_req_wdata),
    .mem_req_mtype(mem_req_mtype),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .q_page(q_page), .q_range(q_range),
    .eff_type(eff_type), .policy(policy), .illegal(illegal),
    .st_idx(st_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_line(rd_line),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .word_en(word_en), .word_off(word_off), .word_data(word_data),
    .word_dirty(word_dirty), .inval_en(inval_en), .clean_en(clean_en)
  );
endmodule

// File: rtl/mtc_cache_chk.sv
module mtc_cache_chk #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int WPL = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [7:0]        cpu_req_mtype,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_error,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [AW-1:0]     mem_req_addr,
  input logic [WPL-1:0]    mem_req_mask,
  input logic [DW*WPL-1:0] mem_req_wdata,
  input logic [7:0]        mem_req_mtype
);
  logic accept, bad_code, err_pend;

  assign accept   = cpu_req_valid && cpu_req_ready;
  assign bad_code = !(cpu_req_mtype inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7});

  always_ff @(posedge clk) begin
    if (!rst_n) err_pend <= 1'b0;
    else if (accept) err_pend <= bad_code;
    else if (cpu_rsp_valid) err_pend <= 1'b0;
  end

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cpu_req_ready);

  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  p_rsp_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  p_bad_code_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_code) |=> ##1 (cpu_rsp_valid && cpu_rsp_error));

  p_bad_code_nobus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend |-> !mem_req_valid);

  p_bypass_word_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && mem_req_mtype inside {8'd0, 8'd1})
      |-> $countones(mem_req_mask) == 1);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_mask) && $stable(mem_req_wdata) && $stable(mem_req_mtype)));
endmodule

bind mtc_cache mtc_cache_chk #(.AW(AW), .DW(DW), .WPL(WPL)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_mtype(cpu_req_mtype),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_error(cpu_rsp_error),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_mask(mem_req_mask), .mem_req_wdata(mem_req_wdata),
  .mem_req_mtype(mem_req_mtype)
);

// File: tb/mtc_cache_test.sv
module mtc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [7:0]  cpu_req_addr, cpu_req_wdata, cpu_req_mtype, cpu_req_range_mtype;
  logic        cpu_rsp_valid, cpu_rsp_error;
  logic [7:0]  cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [7:0]  mem_req_addr, mem_req_mtype;
  logic [1:0]  mem_req_mask;
  logic [15:0] mem_req_wdata, mem_rsp_data;
  logic        mem_rsp_valid;

  always #2.5 clk = ~clk;

  mtc_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_mtype(cpu_req_mtype),
    .cpu_req_range_mtype(cpu_req_range_mtype),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_error(cpu_rsp_error),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_mask(mem_req_mask), .mem_req_wdata(mem_req_wdata),
    .mem_req_mtype(mem_req_mtype),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic       mv [4];
  logic       md [4];
  logic [4:0] mt [4];

  int n_lw, n_lr, n_ww, n_wr, seq, first_lw, first_lr, n_tbad;
  logic [7:0]  exp_type;
  logic [15:0] mlfsr = 16'hACE1;
  logic        pend, hold_armed, done;
  int          dly;
  logic [15:0] pline, h_wdata;
  logic [7:0]  h_addr, h_type;
  logic [1:0]  h_mask;
  logic        h_write;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: decides ready, answers reads, applies writes, counts traffic
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    pend = 1'b0; hold_armed = 1'b0; dly = 0; pline = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = pline; pend = 1'b0;
        end else dly--;
      end
      if (hold_armed) begin
        check(mem_req_valid && mem_req_addr == h_addr && mem_req_write == h_write &&
              mem_req_mask == h_mask && mem_req_wdata == h_wdata &&
              mem_req_mtype == h_type, "R10", "request held under stall",
              int'(mem_req_addr), int'(h_addr));
        hold_armed = 1'b0;
      end
      mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
      mem_req_ready = (mlfsr[1:0] != 2'b00);
      if (rst_n && mem_req_valid && !mem_req_ready) begin
        hold_armed = 1'b1; h_addr = mem_req_addr; h_write = mem_req_write;
        h_mask = mem_req_mask; h_wdata = mem_req_wdata; h_type = mem_req_mtype;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        seq++;
        for (int w = 0; w < 2; w++) begin
          if (mem_req_write && mem_req_mask[w])
            mem[{mem_req_addr[7:1], w[0]}] = mem_req_wdata[w*8 +: 8];
          pline[w*8 +: 8] = mem[{mem_req_addr[7:1], w[0]}];
        end
        if (mem_req_mask == 2'b11) begin
          if (mem_req_write) begin n_lw++; if (first_lw == 0) first_lw = seq; end
          else begin n_lr++; if (first_lr == 0) first_lr = seq; end
        end else begin
          if (mem_req_write) n_ww++; else n_wr++;
          if (mem_req_mtype != exp_type) n_tbad++;
        end
        if (!mem_req_write) begin pend = 1'b1; dly = int'(mlfsr[3:2]); end
      end
    end
  end

  task automatic access(input logic [7:0] a, input bit w, input logic [7:0] d,
                        input logic [7:0] pt, input logic [7:0] rt);
    bit err, bypass, hit, fast;
    logic [7:0] eff;
    int e_lw, e_lr, e_ww, e_wr, lat;
    logic [1:0] ix;
    logic [4:0] tg;
    string rq;
    err = !(pt inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7});
    eff = (pt == 8'd7) ? ((rt == 8'd1) ? 8'd1 : 8'd0) : pt;
    bypass = (eff == 8'd0 || eff == 8'd1);
    ix = a[2:1]; tg = a[7:3];
    hit = mv[ix] && mt[ix] == tg;
    e_lw = 0; e_lr = 0; e_ww = 0; e_wr = 0; fast = 1'b0;
    if (err) begin rq = "R2"; fast = 1'b1; end
    else if (bypass || (eff == 8'd5 && w)) begin
      rq = bypass ? "R3" : "R6";
      if (hit) begin if (md[ix]) e_lw = 1; mv[ix] = 1'b0; md[ix] = 1'b0; end
      if (w) e_ww = 1; else e_wr = 1;
    end else if (eff == 8'd4 && w) begin
      rq = "R5"; e_ww = 1;
    end else begin
      rq = w ? "R7" : "R4";
      if (hit) fast = 1'b1;
      else begin
        if (mv[ix] && md[ix]) e_lw = 1;
        e_lr = 1; mv[ix] = 1'b1; mt[ix] = tg; md[ix] = 1'b0;
      end
      if (w) md[ix] = 1'b1;
    end

    n_lw = 0; n_lr = 0; n_ww = 0; n_wr = 0; seq = 0;
    first_lw = 0; first_lr = 0; n_tbad = 0; exp_type = eff;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
    cpu_req_wdata = d; cpu_req_mtype = pt; cpu_req_range_mtype = rt;
    lat = 0;
    do begin
      @(negedge clk);
      cpu_req_valid = 1'b0;
      lat++;
    end while (!cpu_rsp_valid && lat < 300);

    check(cpu_rsp_error == err, "R2", "error flag", int'(cpu_rsp_error), int'(err));
    if (!w && !err)
      check(cpu_rsp_rdata == shadow[a], rq, "read data", int'(cpu_rsp_rdata), int'(shadow[a]));
    check(n_ww == e_ww, rq, "word writes", n_ww, e_ww);
    check(n_wr == e_wr, rq, "word reads", n_wr, e_wr);
    check(n_lr == e_lr, rq, "line fetches", n_lr, e_lr);
    check(n_lw == e_lw, "R8", "line write-backs", n_lw, e_lw);
    if (e_lw > 0 && e_lr > 0)
      check(first_lw < first_lr, "R8", "write-back before fetch", first_lw, first_lr);
    check(n_tbad == 0, "R1", "resolved type on bus", n_tbad, 0);
    if (fast) check(lat == 2, "R9", "fast-path latency", lat, 2);
    else      check(lat > 2, "R9", "slow-path latency", lat, 3);
    if (w && !err) shadow[a] = d;
  endtask

  initial begin
    done = 1'b0;
    fork
      begin
        repeat (190000) @(posedge clk);
        if (!done) begin
          n_cmp++; n_bad++;
          $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
          $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  pt, rt;
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0;
    cpu_req_wdata = '0; cpu_req_mtype = '0; cpu_req_range_mtype = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R9", "ready after reset", int'(cpu_req_ready), 1);
    check(cpu_rsp_valid == 1'b0, "R9", "no response after reset", int'(cpu_rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R9", "no bus request after reset", int'(mem_req_valid), 0);

    // directed: dirty line then bypass and write-protect accesses to it
    access(8'h03, 1'b1, 8'hC3, 8'd6, 8'd0);
    access(8'h03, 1'b0, 8'h00, 8'd2, 8'd0);
    access(8'h03, 1'b0, 8'h00, 8'd6, 8'd0);
    access(8'h03, 1'b0, 8'h00, 8'd7, 8'd1);
    access(8'h0B, 1'b1, 8'h11, 8'd6, 8'd0);
    access(8'h0A, 1'b1, 8'h22, 8'd5, 8'd0);
    access(8'h13, 1'b1, 8'h33, 8'd4, 8'd6);
    access(8'h13, 1'b0, 8'h00, 8'd4, 8'd6);
    access(8'h13, 1'b1, 8'h44, 8'd4, 8'd6);
    access(8'h13, 1'b0, 8'h00, 8'd5, 8'd6);
    access(8'h1B, 1'b1, 8'h55, 8'd6, 8'd0);
    access(8'h0B, 1'b0, 8'h00, 8'd7, 8'd6);

    // every page code once, with both range types
    for (int c = 0; c < 256; c++) begin
      access(8'(c) & 8'h1F, 1'b0, 8'h00, 8'(c), 8'd1);
      access((8'(c) + 8'd7) & 8'h1F, 1'b1, 8'(c) ^ 8'hA5, 8'(c), 8'd0);
    end

    // long mixed sequence over a small window
    r = 16'h1D2C;
    for (int i = 0; i < 2500; i++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      case (r[10:8])
        3'd0: pt = 8'd0;  3'd1: pt = 8'd1;  3'd2: pt = 8'd4;  3'd3: pt = 8'd5;
        3'd4: pt = 8'd6;  3'd5: pt = 8'd7;  3'd6: pt = 8'd6;  default: pt = 8'd4;
      endcase
      if (r[15:12] == 4'd0) pt = (r[11]) ? 8'hFF : 8'd3;
      rt = r[11] ? 8'd1 : 8'd6;
      access({3'b000, r[4:0]}, r[7], r[15:8] ^ 8'(i), pt, rt);
    end

    // drain: uncached read of every address writes back all dirty lines
    for (int a = 0; a < 256; a++) access(8'(a), 1'b0, 8'h00, 8'd0, 8'd0);
    begin
      int diff = 0;
      for (int a = 0; a < 256; a++) if (mem[a] !== shadow[a]) diff++;
      check(diff == 0, "R7", "memory image after drain", diff, 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule